// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block evaluates integer expressions written in postfix form. It keeps its operands on a small internal last-in first-out stack. It accepts one command per handshake: a push of an immediate word, a pop that returns the top word, or one of four binary operations (add, subtract, multiply, divide). A binary operation names no operands. It always combines the entry just below the top (the left operand) with the top entry (the right operand), and it leaves a single result in their place. A caller can therefore evaluate an expression such as (A-B)/(C+D*E) by streaming pushes and operators and then popping the answer.

Every command except a valid divide takes one cycle. A divide runs through a bit-serial restoring divider, and `cmd_ready` is held low while it runs. Illegal requests do not touch the stack. These are a push onto a full stack, an operation with too few entries, and a divide by zero. Each one is reported by a one-cycle error pulse instead.

The control is a two-state machine. In `S_READY` the unit accepts commands. A valid divide takes the transition `start_divide` to `S_DIVIDE`. When the divider reports completion, the transition `divide_done` writes the quotient back and returns to `S_READY`.

Top module: `stack_calc`

## Requirements
- R1: After reset the stack is empty, `cmd_ready` is high, and `res_valid` and all three error flags are low.
- R2: Opcode 0 (push) places `cmd_data` on the stack. Opcode 1 (pop) removes the top entry and presents it on `res_data` with `res_valid` high for one cycle, starting in the cycle after acceptance. Entries come back in last-in first-out order.
- R3: Opcode 2 (add) and opcode 3 (subtract) replace the two top entries with (second + top) and (second - top), both modulo 2^DATA_W.
- R4: Opcode 4 (multiply) replaces the two top entries with the low DATA_W bits of second * top.
- R5: Opcode 5 (divide) replaces the two top entries with the unsigned quotient second / top.
- R6: A push while the stack holds DEPTH entries pulses `err_overflow` for one cycle and leaves the stack unchanged.
- R7: A pop on an empty stack, or a binary operation with fewer than two entries, pulses `err_underflow` for one cycle and leaves the stack unchanged.
- R8: A divide whose top entry is zero pulses `err_divzero` for one cycle, leaves the stack unchanged, and does not drop `cmd_ready`.
- R9: After a divide with a non-zero divisor is accepted, `cmd_ready` stays low for exactly DATA_W+1 cycles. It stays high after every other command.
- R10: Opcodes 6 and 7 are accepted and have no effect on the stack or the outputs.
- R11: The command sequence push A, push B, sub, push C, push D, push E, mul, add, div, pop returns (A-B)/(C+D*E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Opcode (0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div, 6-7 none) |
| cmd_data | input | DATA_W | Immediate word for push |
| res_valid | output | 1 | `res_data` holds a popped word |
| res_data | output | DATA_W | Popped word |
| err_overflow | output | 1 | Push onto a full stack was rejected |
| err_underflow | output | 1 | Too few entries for the command |
| err_divzero | output | 1 | Divide by zero was rejected |

## Verification
The bench builds the unit with DATA_W = 16 and DEPTH = 4. The shallow stack means four pushes fill it, so overflow and the last-in first-out order of a full stack come up within a few commands. At the same time it is still deep enough to hold the four live entries of the reference expression. The 16-bit width keeps wrap-around, product truncation and the DATA_W+1 cycle divide window at their intended sizes.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;

    typedef enum logic [2:0] {
        OPC_PUSH  = 3'd0,
        OPC_POP   = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_SUB   = 3'd3,
        OPC_MUL   = 3'd4,
        OPC_DIV   = 3'd5,
        OPC_NOP6  = 3'd6,
        OPC_NOP7  = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_FOLD = 2'd3
    } stk_op_e;

    typedef enum logic {
        S_READY  = 1'b0,
        S_DIVIDE = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/stack_calc_store.sv
module stack_calc_store
    import stack_calc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  top_idx;
    logic [PTR_W-1:0]  sec_idx;

    // One write-enabled register per stack slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (op == STK_PUSH && int'(count) == i) begin
                slot[i] <= wr_data;
            end else if (op == STK_FOLD && int'(count) == i + 2) begin
                slot[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                STK_PUSH: count <= count + 1'b1;
                STK_POP,
                STK_FOLD: count <= count - 1'b1;
                default:  count <= count;
            endcase
        end
    end

    always_comb begin
        top_idx = PTR_W'(count - 1'b1);
        sec_idx = PTR_W'(count - 2'd2);
        top     = (count >= CNT_W'(1)) ? slot[top_idx] : '0;
        second  = (count >= CNT_W'(2)) ? slot[sec_idx] : '0;
    end

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH) |=> (count <= CNT_W'(DEPTH)));

    a_r7_fold_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_FOLD) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/stack_calc_divider.sv
module stack_calc_divider #(
    parameter int DATA_W = 16,
    localparam int IT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              done,
    output logic [DATA_W-1:0] quotient
);

    logic [DATA_W:0]   rem;
    logic [DATA_W-1:0] quo;
    logic [DATA_W-1:0] dsr;
    logic [IT_W-1:0]   iter;
    logic              busy;
    logic [DATA_W:0]   shifted;
    logic [DATA_W:0]   diff;

    always_comb begin
        shifted = {rem[DATA_W-1:0], quo[DATA_W-1]};
        diff    = shifted - {1'b0, dsr};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            iter <= '0;
            rem  <= '0;
            quo  <= '0;
            dsr  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                iter <= '0;
                rem  <= '0;
                quo  <= dividend;
                dsr  <= divisor;
            end else if (busy) begin
                if (!diff[DATA_W]) begin
                    rem <= diff;
                    quo <= {quo[DATA_W-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    quo <= {quo[DATA_W-2:0], 1'b0};
                end
                iter <= iter + 1'b1;
                if (iter == IT_W'(DATA_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo;

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/stack_calc.sv
module stack_calc
    import stack_calc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              err_overflow,
    output logic              err_underflow,
    output logic              err_divzero
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    ctrl_state_e       state, state_nx;
    stk_op_e           st_op;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] top_w, sec_w;
    logic [CNT_W-1:0]  depth;
    logic              accept;
    logic              div_start, div_done;
    logic [DATA_W-1:0] quotient;
    logic              ev_res, ev_ovf, ev_unf, ev_dz;
    logic [DATA_W-1:0] ev_data;
    logic              have_one, have_two, is_full;
    opcode_e           opc;

    stack_calc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (st_op),
        .wr_data (st_wdata),
        .top     (top_w),
        .second  (sec_w),
        .count   (depth)
    );

    stack_calc_divider #(.DATA_W(DATA_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (sec_w),
        .divisor  (top_w),
        .done     (div_done),
        .quotient (quotient)
    );

    assign cmd_ready = (state == S_READY);
    assign accept    = cmd_valid && cmd_ready;
    assign opc       = opcode_e'(cmd_op);
    assign have_one  = (depth >= CNT_W'(1));
    assign have_two  = (depth >= CNT_W'(2));
    assign is_full   = (depth == FULL_CNT);

    // Command decode and stack control
    always_comb begin
        st_op     = STK_HOLD;
        st_wdata  = cmd_data;
        div_start = 1'b0;
        ev_res    = 1'b0;
        ev_ovf    = 1'b0;
        ev_unf    = 1'b0;
        ev_dz     = 1'b0;
        ev_data   = '0;
        if (state == S_DIVIDE) begin
            if (div_done) begin
                st_op    = STK_FOLD;
                st_wdata = quotient;
            end
        end else if (accept) begin
            unique case (opc)
                OPC_PUSH: begin
                    if (is_full) ev_ovf = 1'b1;
                    else         st_op  = STK_PUSH;
                end
                OPC_POP: begin
                    if (!have_one) begin
                        ev_unf = 1'b1;
                    end else begin
                        st_op   = STK_POP;
                        ev_res  = 1'b1;
                        ev_data = top_w;
                    end
                end
                OPC_ADD, OPC_SUB, OPC_MUL: begin
                    if (!have_two) begin
                        ev_unf = 1'b1;
                    end else begin
                        st_op = STK_FOLD;
                        if (opc == OPC_ADD)      st_wdata = sec_w + top_w;
                        else if (opc == OPC_SUB) st_wdata = sec_w - top_w;
                        else                     st_wdata = DATA_W'(sec_w * top_w);
                    end
                end
                OPC_DIV: begin
                    if (!have_two)            ev_unf    = 1'b1;
                    else if (top_w == '0)     ev_dz     = 1'b1;
                    else                      div_start = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Next-state logic: start_divide and divide_done transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_READY:  if (div_start) state_nx = S_DIVIDE;
            S_DIVIDE: if (div_done)  state_nx = S_READY;
            default:  state_nx = S_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_READY;
        else        state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_data      <= '0;
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
            err_divzero   <= 1'b0;
        end else begin
            res_valid     <= ev_res;
            err_overflow  <= ev_ovf;
            err_underflow <= ev_unf;
            err_divzero   <= ev_dz;
            if (ev_res) res_data <= ev_data;
        end
    end

    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, err_overflow, err_underflow, err_divzero}));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op == STK_PUSH) |-> (depth < FULL_CNT));

    a_r7_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op == STK_POP) |-> (depth != '0));

    a_r7_fold_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (st_op == STK_FOLD) |-> (depth >= CNT_W'(2)));

    a_r2_pop_result: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && opc == OPC_POP && depth != '0) |=> res_valid);

    a_r8_divzero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && opc == OPC_DIV && depth >= CNT_W'(2) && top_w == '0)
            |=> (err_divzero && cmd_ready));

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |=> !cmd_ready);

endmodule

// File: tb/stack_calc_tb_top.sv
module stack_calc_tb_top;

    localparam int W     = 16;
    localparam int DEPTH = 4;
    localparam logic [1:0] K_RES = 2'd0, K_OVF = 2'd1, K_UNF = 2'd2, K_DZ = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = 3'd0;
    logic [W-1:0] cmd_data = '0;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         err_overflow, err_underflow, err_divzero;

    int tests = 0;
    int fails = 0;

    logic [1:0]   q_kind [$];
    logic [W-1:0] q_val  [$];
    string        q_req  [$];

    always #4 clk = ~clk;

    stack_calc #(.DATA_W(W), .DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_op        (cmd_op),
        .cmd_data      (cmd_data),
        .res_valid     (res_valid),
        .res_data      (res_data),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow),
        .err_divzero   (err_divzero)
    );

    task automatic expect_ev(input logic [1:0] k, input logic [W-1:0] v, input string req);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    // Driver: offers one command, then measures how long ready stays low
    task automatic send(input logic [2:0] op, input logic [W-1:0] d, input int exp_wait, input string req);
        int lowc;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        lowc = 0;
        while (!cmd_ready && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        if (op == 3'd5) tests++;
        if (lowc != exp_wait) begin
            if (op != 3'd5) tests++;
            fails++;
            $display("FAIL %s: ready low for %0d cycles, expected %0d", req, lowc, exp_wait);
        end
    endtask

    task automatic push(input logic [W-1:0] d);
        send(3'd0, d, 0, "R2");
    endtask

    task automatic pop_expect(input logic [W-1:0] v, input string req);
        expect_ev(K_RES, v, req);
        send(3'd1, '0, 0, req);
    endtask

    // Monitor: pops the scoreboard for every observed output event
    always @(negedge clk) begin
        if (rst_n && (res_valid || err_overflow || err_underflow || err_divzero)) begin
            logic [1:0] k;
            k = res_valid ? K_RES : err_overflow ? K_OVF : err_underflow ? K_UNF : K_DZ;
            tests++;
            if (q_kind.size() == 0) begin
                fails++;
                $display("FAIL unexpected event kind %0d data %h, expected none (R10)", k, res_data);
            end else begin
                logic [1:0]   ek;
                logic [W-1:0] ev;
                string        er;
                ek = q_kind.pop_front();
                ev = q_val.pop_front();
                er = q_req.pop_front();
                if (k != ek || (k == K_RES && res_data != ev)) begin
                    fails++;
                    $display("FAIL %s: kind %0d data %h, expected kind %0d data %h", er, k, res_data, ek, ev);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        tests++;
        if (!cmd_ready || res_valid || err_overflow || err_underflow || err_divzero) begin
            fails++;
            $display("FAIL R1: ready=%b rv=%b errs=%b%b%b, expected 1 0 000", cmd_ready, res_valid,
                     err_overflow, err_underflow, err_divzero);
        end
        expect_ev(K_UNF, '0, "R1");
        send(3'd1, '0, 0, "R1");

        // R11 reference expression: (100-20)/(2+3*6) = 4
        push(16'd100); push(16'd20);
        send(3'd3, '0, 0, "R11");
        push(16'd2); push(16'd3); push(16'd6);
        send(3'd4, '0, 0, "R11");
        send(3'd2, '0, 0, "R11");
        send(3'd5, '0, W + 1, "R11");
        pop_expect(16'd4, "R11");

        // R3 operand order and wrap
        push(16'd5); push(16'd9);
        send(3'd3, '0, 0, "R3");
        pop_expect(16'hFFFC, "R3");
        push(16'hFFFF); push(16'd2);
        send(3'd2, '0, 0, "R3");
        pop_expect(16'h0001, "R3");

        // R4 low half of product
        push(16'h1234); push(16'h0100);
        send(3'd4, '0, 0, "R4");
        pop_expect(16'h3400, "R4");
        push(16'hFFFF); push(16'hFFFF);
        send(3'd4, '0, 0, "R4");
        pop_expect(16'h0001, "R4");

        // R5 unsigned quotient, R9 busy window
        push(16'd100); push(16'd7);
        send(3'd5, '0, W + 1, "R9");
        pop_expect(16'd14, "R5");
        push(16'hFFFF); push(16'd1);
        send(3'd5, '0, W + 1, "R9");
        pop_expect(16'hFFFF, "R5");
        push(16'd7); push(16'd9);
        send(3'd5, '0, W + 1, "R9");
        pop_expect(16'd0, "R5");

        // R6 overflow keeps contents, R2 LIFO order
        push(16'd1); push(16'd2); push(16'd3); push(16'd4);
        expect_ev(K_OVF, '0, "R6");
        send(3'd0, 16'd5, 0, "R6");
        pop_expect(16'd4, "R6");
        pop_expect(16'd3, "R2");
        pop_expect(16'd2, "R2");
        pop_expect(16'd1, "R2");

        // R7 underflow without effect
        expect_ev(K_UNF, '0, "R7");
        send(3'd1, '0, 0, "R7");
        push(16'd7);
        expect_ev(K_UNF, '0, "R7");
        send(3'd2, '0, 0, "R7");
        expect_ev(K_UNF, '0, "R7");
        send(3'd3, '0, 0, "R7");
        expect_ev(K_UNF, '0, "R7");
        send(3'd5, '0, 0, "R7");
        pop_expect(16'd7, "R7");

        // R8 divide by zero keeps both operands, ready stays high
        push(16'd9); push(16'd0);
        expect_ev(K_DZ, '0, "R8");
        send(3'd5, '0, 0, "R8");
        pop_expect(16'd0, "R8");
        pop_expect(16'd9, "R8");

        // R10 reserved opcodes do nothing
        push(16'd3);
        send(3'd6, 16'hAAAA, 0, "R10");
        send(3'd7, 16'h5555, 0, "R10");
        pop_expect(16'd3, "R10");
        expect_ev(K_UNF, '0, "R10");
        send(3'd1, '0, 0, "R10");

        repeat (5) @(negedge clk);
        tests++;
        if (q_kind.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d expected events missing, expected 0", q_kind.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule